// File: doc/BRIEF.md
# UART Channel Interrupt and DMA-Ready Controller

This block holds the interrupt and transfer-ready logic of one UART channel whose transmit and receive FIFOs hold 16 characters each. It watches FIFO occupancy, the programmed receive trigger level, a receive time-out pulse, the line error flags and four modem input lines. From these it produces a prioritized interrupt identification byte, an interrupt request and two active-low DMA request pins. Those pins behave differently in single-character transfer mode and in block transfer mode.

The block also keeps four modem change bits, one for each modem line. A bit sets whenever its line toggles and clears when the CPU reads the modem status byte. The FIFOs, the serial shifter and the bus decoder sit outside the block. Their strobes (status read, modem status read, holding register write, receive register read) arrive as single-cycle pulses.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, with FIFOs off and both FIFOs empty, `isr_o` is 8'h01, `int_o` is 0, `msr_o` is 8'h00, `txrdy_no` is 0 and `rxrdy_no` is 1.
- R2: `isr_o[0]` is 0 while a source is reported, and `isr_o[3:1]` holds the reported source code: line error 3'b011, receive data 3'b010, receive time-out 3'b110, transmit empty 3'b001, modem change 3'b000. `int_o` is 1 exactly when a source is reported. Bits [5:4] read 0.
- R3: Sources are ranked from highest to lowest as line error, then receive time-out or data, then transmit empty, then modem change. A lower source shows only once every higher source has cleared.
- R4: `isr_o[7:6]` read 2'b11 when `fifo_en_i` is 1 and 2'b00 otherwise.
- R5: A toggle on `modem_i[k]` sets change bit `msr_o[k]` at the next clock edge. `msr_o[7:4]` follow the registered lines. A `msr_rd_i` pulse clears the change bits, except that a toggle in the same cycle still sets its own bit.
- R6: Any change bit at 1 with `ier_i[3]` set raises the modem source.
- R7: With `ier_i` all zero, `int_o` stays 0 and `isr_o[0]` stays 1 whatever is pending (polled mode).
- R8: With FIFOs on, a `rx_timeout_i` pulse latches a time-out source from the next edge until a `rhr_rd_i` pulse. With FIFOs off the pulse is ignored.
- R9: The transmit-empty source (enabled by `ier_i[1]`) sets when `tx_count_i` becomes 0, or when `ier_i[1]` rises while the FIFO is empty. It clears on `thr_wr_i`, or on `isr_rd_i` while it is the reported source. A status read that reports another source leaves it set.
- R10: The receive-data source (enabled by `ier_i[0]`) is pending when `rx_count_i >= rx_trig_i` with the FIFO non-empty in FIFO mode, and when `rx_count_i != 0` in non-FIFO mode.
- R11: In single-character mode (`dma_mode_i`=0), `rxrdy_no` is 0 while `rx_count_i != 0`, and `txrdy_no` is 0 only while `tx_count_i == 0`.
- R12: In block mode (`dma_mode_i`=1 with FIFOs on), `rxrdy_no` is 0 when the receive count reaches the trigger level or a time-out is latched. `txrdy_no` is 1 only when `tx_count_i` equals 16.
- R13: With FIFOs off, the DMA pins follow single-character mode whatever `dma_mode_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFOs enabled |
| dma_mode_i | input | 1 | 0 single-character, 1 block transfer |
| ier_i | input | 4 | Enables: [0] rx data/time-out, [1] tx empty, [2] line error, [3] modem |
| rx_count_i | input | 5 | Receive FIFO occupancy |
| rx_trig_i | input | 5 | Receive trigger level |
| rx_timeout_i | input | 1 | Receive time-out pulse |
| rhr_rd_i | input | 1 | Receive register read strobe |
| tx_count_i | input | 5 | Transmit FIFO occupancy |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| lsr_err_i | input | 4 | Line error flags, any bit set is an error |
| isr_rd_i | input | 1 | Interrupt status read strobe |
| modem_i | input | 4 | Modem input lines |
| msr_rd_i | input | 1 | Modem status read strobe |
| isr_o | output | 8 | Interrupt identification byte |
| int_o | output | 1 | Interrupt request |
| msr_o | output | 8 | {registered lines, change bits} |
| txrdy_no | output | 1 | Transmit DMA request, active low |
| rxrdy_no | output | 1 | Receive DMA request, active low |

## Verification
The identification byte, the interrupt request and both DMA pins are combinational from the ports and the latched sources. After a level input changes, the bench checks them one time unit later in the same cycle. The modem change bits, the time-out latch and the transmit-empty latch all move at the first rising edge after their cause. The bench therefore drives each strobe or line toggle on a falling edge, removes it at the next falling edge, and samples there, one edge after the cause. Read strobes that coincide with a toggle are checked the same way, so the set-wins rule is observed in the cycle it applies.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    ID_MODEM   = 3'b000,
    ID_THRE    = 3'b001,
    ID_RXDATA  = 3'b010,
    ID_LINE    = 3'b011,
    ID_TIMEOUT = 3'b110
  } irq_id_e;

  localparam int unsigned EN_RX = 0;
  localparam int unsigned EN_TX = 1;
  localparam int unsigned EN_LS = 2;
  localparam int unsigned EN_MS = 3;
  localparam int unsigned EN_W  = 4;
endpackage

// File: rtl/uart_msr_track.sv
module uart_msr_track #(
  parameter int unsigned LINES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lines_i,
  input  logic             rd_i,
  output logic [LINES-1:0] lines_o,
  output logic [LINES-1:0] delta_o
);
  logic [LINES-1:0] lines_q, delta_q, toggled;
  logic             primed_q;

  assign toggled = primed_q ? (lines_i ^ lines_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_q  <= '0;
      delta_q  <= '0;
      primed_q <= 1'b0;
    end else begin
      lines_q  <= lines_i;
      primed_q <= 1'b1;
      delta_q  <= (delta_q & ~{LINES{rd_i}}) | toggled;
    end
  end

  assign lines_o = lines_q;
  assign delta_o = delta_q;

  AST_MSR_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (lines_i == lines_q) |=> delta_q == '0); // R5
  AST_MSR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && (lines_i != lines_q) |=> (delta_q & $past(lines_i ^ lines_q)) == $past(lines_i ^ lines_q)); // R5
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             ier_tx_i,
  input  logic             thr_wr_i,
  input  logic             isr_rd_i,
  input  logic             thre_shown_i,
  input  logic             rx_timeout_i,
  input  logic             rhr_rd_i,
  output logic             thre_o,
  output logic             timeout_o
);
  logic tx_empty, empty_q, ier_tx_q, thre_q, to_q;
  logic thre_set, thre_clr;

  assign tx_empty = (tx_count_i == '0);
  assign thre_set = (tx_empty & ~empty_q) | (tx_empty & ier_tx_i & ~ier_tx_q);
  assign thre_clr = thr_wr_i | (isr_rd_i & thre_shown_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q  <= 1'b1;
      ier_tx_q <= 1'b0;
      thre_q   <= 1'b0;
      to_q     <= 1'b0;
    end else begin
      empty_q  <= tx_empty;
      ier_tx_q <= ier_tx_i;
      if (thre_set)      thre_q <= 1'b1;
      else if (thre_clr) thre_q <= 1'b0;
      if (rx_timeout_i && fifo_en_i)  to_q <= 1'b1;
      else if (rhr_rd_i || !fifo_en_i) to_q <= 1'b0;
    end
  end

  assign thre_o    = thre_q;
  assign timeout_o = to_q;

  AST_THRE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i && !thre_set |=> !thre_o); // R9
  AST_TO_NONFIFO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> !timeout_o); // R8
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fifo_en_i,
  input  logic [EN_W-1:0] ier_i,
  input  logic            line_err_i,
  input  logic            rx_avail_i,
  input  logic            timeout_i,
  input  logic            thre_i,
  input  logic            delta_any_i,
  output logic [7:0]      isr_o,
  output logic            int_o,
  output logic            thre_shown_o
);
  logic    ls_p, to_p, rx_p, tx_p, ms_p, any_p;
  irq_id_e id;

  assign ls_p  = ier_i[EN_LS] & line_err_i;
  assign to_p  = ier_i[EN_RX] & timeout_i;
  assign rx_p  = ier_i[EN_RX] & rx_avail_i;
  assign tx_p  = ier_i[EN_TX] & thre_i;
  assign ms_p  = ier_i[EN_MS] & delta_any_i;
  assign any_p = ls_p | to_p | rx_p | tx_p | ms_p;

  always_comb begin
    if (ls_p)      id = ID_LINE;
    else if (to_p) id = ID_TIMEOUT;
    else if (rx_p) id = ID_RXDATA;
    else if (tx_p) id = ID_THRE;
    else           id = ID_MODEM;
  end

  assign isr_o        = {fifo_en_i, fifo_en_i, 2'b00, id, ~any_p};
  assign int_o        = any_p;
  assign thre_shown_o = any_p && (id == ID_THRE);

  AST_POLLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_i == '0 |-> !int_o && isr_o[0]); // R7
  AST_LINE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_p |-> isr_o[3:1] == 3'b011); // R3
  AST_MODEM_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_o[3:1] == 3'b000) && int_o |-> ms_p && !ls_p && !rx_p && !to_p && !tx_p); // R6
endmodule

// File: rtl/uart_dma_rdy.sv
module uart_dma_rdy #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             dma_mode_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             timeout_i,
  input  logic [CNT_W-1:0] tx_count_i,
  output logic             txrdy_no,
  output logic             rxrdy_no
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  logic block, rx_any, rx_trig_hit, rx_act, tx_act;

  assign block       = fifo_en_i & dma_mode_i;
  assign rx_any      = (rx_count_i != '0);
  assign rx_trig_hit = rx_any && (rx_count_i >= rx_trig_i);

  always_comb begin
    if (block) begin
      rx_act = rx_trig_hit | timeout_i;
      tx_act = (tx_count_i < FULL);
    end else begin
      rx_act = rx_any;
      tx_act = (tx_count_i == '0);
    end
  end

  assign rxrdy_no = ~rx_act;
  assign txrdy_no = ~tx_act;

  AST_TX_FULL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block && (tx_count_i == FULL) |-> txrdy_no); // R12
  AST_RX_EMPTY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !block && !rx_any |-> rxrdy_no); // R11
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LINES = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             dma_mode_i,
  input  logic [EN_W-1:0]  ier_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             rx_timeout_i,
  input  logic             rhr_rd_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             thr_wr_i,
  input  logic [3:0]       lsr_err_i,
  input  logic             isr_rd_i,
  input  logic [LINES-1:0] modem_i,
  input  logic             msr_rd_i,
  output logic [7:0]       isr_o,
  output logic             int_o,
  output logic [2*LINES-1:0] msr_o,
  output logic             txrdy_no,
  output logic             rxrdy_no
);
  logic [LINES-1:0] lines, delta;
  logic thre, timeout, thre_shown, rx_avail;

  assign rx_avail = fifo_en_i ? ((rx_count_i != '0) && (rx_count_i >= rx_trig_i))
                              : (rx_count_i != '0);

  uart_msr_track #(.LINES(LINES)) u_msr (
    .clk_i, .rst_ni, .lines_i(modem_i), .rd_i(msr_rd_i),
    .lines_o(lines), .delta_o(delta)
  );

  uart_irq_src #(.CNT_W(CNT_W)) u_src (
    .clk_i, .rst_ni, .fifo_en_i, .tx_count_i, .ier_tx_i(ier_i[EN_TX]),
    .thr_wr_i, .isr_rd_i, .thre_shown_i(thre_shown), .rx_timeout_i, .rhr_rd_i,
    .thre_o(thre), .timeout_o(timeout)
  );

  uart_irq_prio u_prio (
    .clk_i, .rst_ni, .fifo_en_i, .ier_i, .line_err_i(|lsr_err_i),
    .rx_avail_i(rx_avail), .timeout_i(timeout), .thre_i(thre),
    .delta_any_i(|delta), .isr_o, .int_o, .thre_shown_o(thre_shown)
  );

  uart_dma_rdy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dma (
    .clk_i, .rst_ni, .fifo_en_i, .dma_mode_i, .rx_count_i, .rx_trig_i,
    .timeout_i(timeout), .tx_count_i, .txrdy_no, .rxrdy_no
  );

  assign msr_o = {lines, delta};

  AST_FIFO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_o[7:6] == {2{fifo_en_i}}); // R4
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en_i = 1'b0, dma_mode_i = 1'b0;
  logic [3:0] ier_i = '0;
  logic [4:0] rx_count_i = '0, rx_trig_i = 5'd1, tx_count_i = '0;
  logic       rx_timeout_i = 1'b0, rhr_rd_i = 1'b0, thr_wr_i = 1'b0;
  logic [3:0] lsr_err_i = '0, modem_i = '0;
  logic       isr_rd_i = 1'b0, msr_rd_i = 1'b0;
  logic [7:0] isr_o, msr_o;
  logic       int_o, txrdy_no, rxrdy_no;
  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  uart_irq_ctrl u_dut (
    .clk_i, .rst_ni, .fifo_en_i, .dma_mode_i, .ier_i, .rx_count_i, .rx_trig_i,
    .rx_timeout_i, .rhr_rd_i, .tx_count_i, .thr_wr_i, .lsr_err_i, .isr_rd_i,
    .modem_i, .msr_rd_i, .isr_o, .int_o, .msr_o, .txrdy_no, .rxrdy_no
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk_i);
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic t_reset;
    tick; tick; settle;
    chk("R1 isr", isr_o, 8'h01);
    chk("R1 int", {7'd0, int_o}, 8'h00);
    chk("R1 msr", msr_o, 8'h00);
    chk("R1 pins", {6'd0, txrdy_no, rxrdy_no}, 8'h01);
  endtask

  task automatic t_priority;
    fifo_en_i = 1'b1; ier_i = 4'hF; tick; settle;
    chk("R9 ier rise sets tx empty", isr_o, 8'hC2);
    chk("R2 int", {7'd0, int_o}, 8'h01);
    rx_count_i = 5'd4; rx_trig_i = 5'd4; settle;
    chk("R10 rx at trigger", isr_o, 8'hC4);
    lsr_err_i = 4'b0001; settle;
    chk("R3 line error on top", isr_o, 8'hC6);
    modem_i = 4'b0001; tick; settle;
    chk("R3 modem hidden", isr_o, 8'hC6);
    lsr_err_i = '0; settle;
    chk("R3 rx after line clears", isr_o, 8'hC4);
    rx_count_i = 5'd3; settle;
    chk("R10 below trigger", isr_o, 8'hC2);
    isr_rd_i = 1'b1; tick; isr_rd_i = 1'b0; settle;
    chk("R9 read clears tx empty", isr_o, 8'hC0);
    chk("R6 modem int", {7'd0, int_o}, 8'h01);
    msr_rd_i = 1'b1; tick; msr_rd_i = 1'b0; settle;
    chk("R5 msr read clears", msr_o, 8'h10);
    chk("R2 idle", isr_o, 8'hC1);
    chk("R2 int low", {7'd0, int_o}, 8'h00);
  endtask

  task automatic t_polled;
    ier_i = 4'h0; lsr_err_i = 4'b0100; rx_count_i = 5'd9; modem_i = 4'b0000; tick; settle;
    chk("R7 isr polled", isr_o, 8'hC1);
    chk("R7 int polled", {7'd0, int_o}, 8'h00);
    lsr_err_i = '0; rx_count_i = '0;
    msr_rd_i = 1'b1; tick; msr_rd_i = 1'b0; settle;
    chk("R5 msr", msr_o, 8'h00);
  endtask

  task automatic t_modem;
    ier_i = 4'h8; modem_i = 4'b0010; tick; settle;
    chk("R5 set on toggle", msr_o, 8'h22);
    chk("R6 modem id", isr_o, 8'hC0);
    msr_rd_i = 1'b1; modem_i = 4'b0011; tick; msr_rd_i = 1'b0; settle;
    chk("R5 toggle beats read", msr_o, 8'h31);
    msr_rd_i = 1'b1; tick; msr_rd_i = 1'b0; settle;
    chk("R5 cleared", msr_o, 8'h30);
    chk("R6 no int", {7'd0, int_o}, 8'h00);
    ier_i = 4'h0; modem_i = 4'b0000; tick;
    msr_rd_i = 1'b1; tick; msr_rd_i = 1'b0; settle;
  endtask

  task automatic t_timeout;
    ier_i = 4'h1; dma_mode_i = 1'b1; rx_count_i = 5'd2; rx_trig_i = 5'd8; settle;
    chk("R12 rx below trigger", {7'd0, rxrdy_no}, 8'h01);
    rx_timeout_i = 1'b1; tick; rx_timeout_i = 1'b0; settle;
    chk("R8 timeout id", isr_o, 8'hCC);
    chk("R12 rx timeout pin", {7'd0, rxrdy_no}, 8'h00);
    rhr_rd_i = 1'b1; tick; rhr_rd_i = 1'b0; settle;
    chk("R8 cleared by read", isr_o, 8'hC1);
    chk("R12 rx pin released", {7'd0, rxrdy_no}, 8'h01);
    rx_count_i = '0; dma_mode_i = 1'b0;
  endtask

  task automatic t_thre;
    tx_count_i = 5'd5; ier_i = 4'h0; tick;
    ier_i = 4'h2; tick; settle;
    chk("R9 no set while busy", isr_o, 8'hC1);
    tx_count_i = '0; tick; settle;
    chk("R9 set on drain", isr_o, 8'hC2);
    thr_wr_i = 1'b1; tick; thr_wr_i = 1'b0; settle;
    chk("R9 write clears", isr_o, 8'hC1);
    ier_i = 4'h3; rx_count_i = 5'd8; rx_trig_i = 5'd8; tx_count_i = 5'd3; tick;
    tx_count_i = '0; tick; settle;
    chk("R3 rx over tx empty", isr_o, 8'hC4);
    isr_rd_i = 1'b1; tick; isr_rd_i = 1'b0; rx_count_i = '0; settle;
    chk("R9 kept when other shown", isr_o, 8'hC2);
    thr_wr_i = 1'b1; tick; thr_wr_i = 1'b0; ier_i = 4'h0;
  endtask

  task automatic t_dma;
    fifo_en_i = 1'b1; dma_mode_i = 1'b0; rx_count_i = '0; tx_count_i = '0; settle;
    chk("R11 empty", {6'd0, txrdy_no, rxrdy_no}, 8'h01);
    rx_count_i = 5'd1; tx_count_i = 5'd1; settle;
    chk("R11 one each", {6'd0, txrdy_no, rxrdy_no}, 8'h02);
    dma_mode_i = 1'b1; rx_trig_i = 5'd4; rx_count_i = 5'd3; tx_count_i = 5'd15; settle;
    chk("R12 below trig, room", {6'd0, txrdy_no, rxrdy_no}, 8'h01);
    rx_count_i = 5'd4; tx_count_i = 5'd16; settle;
    chk("R12 at trig, full", {6'd0, txrdy_no, rxrdy_no}, 8'h02);
  endtask

  task automatic t_nonfifo;
    fifo_en_i = 1'b0; dma_mode_i = 1'b1; ier_i = 4'h1; tx_count_i = 5'd1;
    rx_count_i = 5'd1; rx_trig_i = 5'd4; settle;
    chk("R13 pins", {6'd0, txrdy_no, rxrdy_no}, 8'h02);
    chk("R10 R4 rx nonfifo", isr_o, 8'h04);
    rx_timeout_i = 1'b1; tick; rx_timeout_i = 1'b0; rx_count_i = '0; settle;
    chk("R8 ignored nonfifo", isr_o, 8'h01);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick; tick;
    rst_ni = 1'b1;
    t_reset;
    t_priority;
    t_polled;
    t_modem;
    t_timeout;
    t_thre;
    t_dma;
    t_nonfifo;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule